// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider with Fractional Averaging

The block divides a fast clock by a programmable modulus and marks the end of each division period with a pulse that is high for one input cycle. It sits in the feedback path of a frequency synthesiser. The integer part of the modulus comes from a 12-bit field N and a 4-bit adjust field A.

A 6-bit offset, counted in sixty-fourths of a cycle, can be switched on to give a fractional ratio. It is realised by stretching selected periods by one cycle. The stretched periods are chosen so that every run of 64 consecutive periods is exactly OFFSET cycles longer than 64 plain periods.

A simple mode takes the modulus directly from N. Configuration is sampled only at period boundaries, so no period is ever cut short by a reprogramming.

Top module: `fbdiv_top`

## Requirements
- R1: While rst_ni is low, pulse_o is low and the period counter and fractional accumulator are cleared. The first pulse is sampled exactly M cycles after the first rising clock edge following reset release.
- R2: With simple_i=0, N>=1 and A=0, every period lasts 2*N input cycles.
- R3: With simple_i=0, N>=1 and A in 1..15, every period lasts 2*N+A+1 input cycles.
- R4: With simple_i=1 and N>=1, every period lasts N cycles, whatever A, OFFSET and frac_en_i hold.
- R5: N=0 selects the slowest ratio, a period of 8206 cycles, in both modes and with the fractional offset ignored.
- R6: cfg_err_o is high exactly when simple_i=0, A is nonzero and A+1 >= N (so it is high for N=0 with nonzero A). It is always low in simple mode.
- R7: With frac_en_i=1, simple_i=0 and N>=1, each period lasts M or M+1 cycles, and any 64 consecutive periods total 64*M+OFFSET cycles.
- R8: With frac_en_i=0, every period lasts exactly M cycles, whatever OFFSET holds.
- R9: N, A, OFFSET and the mode bits are sampled on the last cycle of a period. A change made within a period leaves that period's length unchanged and applies from the next period.
- R10: pulse_o is high for a single input cycle per period; with a modulus of 1 it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_i | input | 12 | Integer field N |
| a_i | input | 4 | Adjust field A (0 means -1) |
| offset_i | input | 6 | Fractional offset in 1/64 cycle |
| frac_en_i | input | 1 | Enables fractional averaging |
| simple_i | input | 1 | Modulus equals N; A and offset ignored |
| pulse_o | output | 1 | High on the last cycle of each period |
| cfg_err_o | output | 1 | Adjust field out of its legal range |

## Verification
The fractional behaviour is the hardest part to observe from the ports. It shows only as the positions of the stretched periods, and it can be judged only over a whole window of 64 periods. The accumulator also carries its state across reconfigurations.

The stimulus therefore holds each offset value from 0 to 63 for a full window. The window starts right at a pulse, so the new offset takes effect in its first period. The bench then compares the summed window length with the exact arithmetic total. This holds whatever residue the accumulator had when the window started.

Boundary sampling is tested by changing N partway through a long period and timing both that period and the one after it.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int N_W   = 12;
  localparam int A_W   = 4;
  localparam int F_W   = 6;
  localparam int M_W   = N_W + 2;
  localparam int M_MAX = (2 ** (N_W + 1)) - 2 + (2 ** A_W);

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
    logic [F_W-1:0] off;
    logic           frac_en;
    logic           simple;
  } fbdiv_cfg_t;
endpackage

// File: rtl/fbdiv_modulus.sv
module fbdiv_modulus
  import fbdiv_pkg::*;
(
  input  fbdiv_cfg_t     cfg_i,
  output logic [M_W-1:0] mod_o,
  output logic           frac_on_o,
  output logic           err_o
);
  logic [M_W-1:0] n_ext;
  logic [M_W-1:0] a_ext;
  logic [M_W-1:0] m_norm;
  logic           n_zero;

  always_comb begin
    n_ext  = M_W'(cfg_i.n);
    a_ext  = M_W'(cfg_i.a);
    n_zero = (cfg_i.n == '0);
    // A=0 encodes -1: 2N-1+1 = 2N
    m_norm = (n_ext << 1) + ((cfg_i.a == '0) ? M_W'(0) : (a_ext + M_W'(1)));
    if (n_zero)            mod_o = M_W'(M_MAX);
    else if (cfg_i.simple) mod_o = n_ext;
    else                   mod_o = m_norm;
    frac_on_o = cfg_i.frac_en && !cfg_i.simple && !n_zero;
    err_o     = !cfg_i.simple && (cfg_i.a != '0) && ((a_ext + M_W'(1)) >= n_ext);
  end
endmodule

// File: rtl/fbdiv_frac_acc.sv
module fbdiv_frac_acc
  import fbdiv_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           en_i,
  input  logic [F_W-1:0] off_i,
  output logic           carry_o,
  output logic [F_W-1:0] acc_o
);
  logic [F_W-1:0] acc_q;
  logic [F_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, off_i};
  assign carry_o = en_i & sum[F_W];
  assign acc_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= en_i ? sum[F_W-1:0] : '0;
  end
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
  import fbdiv_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] len_i,
  output logic           load_o,
  output logic           pulse_o,
  output logic [M_W-1:0] cnt_o
);
  logic           started_q;
  logic [M_W-1:0] cnt_q;

  assign load_o  = (cnt_q == '0);
  assign pulse_o = started_q & load_o;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (load_o) cnt_q <= len_i - M_W'(1);
      else        cnt_q <= cnt_q - M_W'(1);
    end
  end
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic [F_W-1:0] offset_i,
  input  logic           frac_en_i,
  input  logic           simple_i,
  output logic           pulse_o,
  output logic           cfg_err_o
);
  fbdiv_cfg_t     cfg;
  logic [M_W-1:0] mod;
  logic           frac_on;
  logic           carry;
  logic           load;
  logic [M_W-1:0] len;
  logic [M_W-1:0] cnt_q;
  logic [F_W-1:0] acc_q;

  always_comb begin
    cfg.n       = n_i;
    cfg.a       = a_i;
    cfg.off     = offset_i;
    cfg.frac_en = frac_en_i;
    cfg.simple  = simple_i;
  end

  fbdiv_modulus i_mod (
    .cfg_i     (cfg),
    .mod_o     (mod),
    .frac_on_o (frac_on),
    .err_o     (cfg_err_o)
  );

  fbdiv_frac_acc i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (load),
    .en_i    (frac_on),
    .off_i   (offset_i),
    .carry_o (carry),
    .acc_o   (acc_q)
  );

  assign len = mod + M_W'(carry);

  fbdiv_counter i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .len_i   (len),
    .load_o  (load),
    .pulse_o (pulse_o),
    .cnt_o   (cnt_q)
  );
endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker
  import fbdiv_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           simple_i,
  input logic           pulse_o,
  input logic           cfg_err_o,
  input logic           load,
  input logic [M_W-1:0] cnt_q,
  input logic [F_W-1:0] acc_q
);
  localparam int GAP_W = M_W + 1;
  localparam int MAX_L = M_MAX + 2;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    gap_q <= '0;
    else if (pulse_o)               gap_q <= GAP_W'(1);
    else if (gap_q != {GAP_W{1'b1}}) gap_q <= gap_q + GAP_W'(1);
  end

  AST_SIMPLE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simple_i |-> !cfg_err_o); // R6
  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (gap_q <= GAP_W'(MAX_L))); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> (cnt_q == $past(cnt_q) - M_W'(1))); // R9
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(acc_q)); // R7
  AST_PULSE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !load) |-> 1'b0); // R10
endmodule

bind fbdiv_top fbdiv_checker i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .simple_i  (simple_i),
  .pulse_o   (pulse_o),
  .cfg_err_o (cfg_err_o),
  .load      (load),
  .cnt_q     (cnt_q),
  .acc_q     (acc_q)
);

// File: tb/test_fbdiv_top.sv
module test_fbdiv_top;
  import fbdiv_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 200000;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N_W-1:0] n_i = '0;
  logic [A_W-1:0] a_i = '0;
  logic [F_W-1:0] offset_i = '0;
  logic           frac_en_i = 1'b0;
  logic           simple_i = 1'b0;
  logic           pulse_o;
  logic           cfg_err_o;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbdiv_top i_fbdiv_top (
    .clk_i(clk), .rst_ni(rst_ni), .n_i(n_i), .a_i(a_i), .offset_i(offset_i),
    .frac_en_i(frac_en_i), .simple_i(simple_i), .pulse_o(pulse_o), .cfg_err_o(cfg_err_o)
  );

  function automatic int exp_mod(int n, int a, bit sm);
    if (n == 0) return M_MAX;
    if (sm) return n;
    if (a == 0) return 2 * n;
    return 2 * n + a + 1;
  endfunction

  function automatic bit exp_err(int n, int a, bit sm);
    return !sm && (a != 0) && (a + 1 >= n);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(int n, int a, int off, bit fe, bit sm);
    n_i = N_W'(n); a_i = A_W'(a); offset_i = F_W'(off);
    frac_en_i = fe; simple_i = sm;
  endtask

  task automatic get_period(output int p);
    int c = 0;
    do begin @(negedge clk); c++; end while (!pulse_o);
    p = c;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, c, sum, m;
    bit range_ok;
    // R1 reset
    apply(2, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(pulse_o == 1'b0, "R1 reset pulse", int'(pulse_o), 0);
    rst_ni = 1'b1;
    get_period(p);
    chk(p == 4, "R1 first pulse", p, 4);

    // R2 R3 R6 normal sweep
    for (int n = 1; n <= 8; n++) begin
      for (int a = 0; a < 16; a++) begin
        apply(n, a, 0, 0, 0);
        #1;
        chk(cfg_err_o == exp_err(n, a, 0), "R6 err normal", int'(cfg_err_o), int'(exp_err(n, a, 0)));
        get_period(p);
        m = exp_mod(n, a, 0);
        chk(p == m, (a == 0) ? "R2 period" : "R3 period", p, m);
      end
    end

    // R4 simple sweep, A/offset/frac ignored
    for (int n = 1; n <= 24; n++) begin
      apply(n, n % 16, (n * 7) % 64, n[0], 1);
      #1;
      chk(cfg_err_o == 1'b0, "R6 err simple", int'(cfg_err_o), 0);
      get_period(p);
      chk(p == n, "R4 simple period", p, n);
    end

    // R10 one-cycle pulse; continuous with modulus 1
    apply(1, 0, 0, 0, 1);
    get_period(p);
    get_period(p);
    chk(p == 1 && pulse_o, "R10 modulus 1 high", p, 1);
    apply(5, 0, 0, 0, 1);
    get_period(p);
    @(negedge clk);
    chk(pulse_o == 1'b0, "R10 single cycle", int'(pulse_o), 0);
    get_period(p);
    chk(p == 4, "R10 rest of period", p, 4);

    // R5 N=0
    apply(0, 3, 10, 1, 0);
    #1;
    chk(cfg_err_o == 1'b1, "R6 err n0", int'(cfg_err_o), 1);
    get_period(p);
    chk(p == M_MAX, "R5 n0 normal", p, M_MAX);
    apply(0, 0, 0, 0, 1);
    get_period(p);
    chk(p == M_MAX, "R5 n0 simple", p, M_MAX);

    // R8 fraction disabled
    apply(3, 2, 37, 0, 0);
    sum = 0;
    for (int k = 0; k < 8; k++) begin get_period(p); sum += p; end
    chk(sum == 72, "R8 no fraction", sum, 72);

    // R7 fractional sweep, M=9
    for (int off = 0; off < 64; off++) begin
      apply(3, 2, off, 1, 0);
      sum = 0; range_ok = 1'b1;
      for (int k = 0; k < 64; k++) begin
        get_period(p); sum += p;
        if (p != 9 && p != 10) range_ok = 1'b0;
      end
      chk(sum == 64 * 9 + off, "R7 window sum", sum, 64 * 9 + off);
      chk(range_ok, "R7 period range", int'(range_ok), 1);
    end
    apply(1, 0, 63, 1, 0);
    sum = 0;
    for (int k = 0; k < 64; k++) begin get_period(p); sum += p; end
    chk(sum == 128 + 63, "R7 M=2 off=63", sum, 191);

    // R9 mid-period change
    apply(10, 0, 0, 0, 0);
    get_period(p);
    chk(p == 20, "R9 before change", p, 20);
    c = 0;
    repeat (5) begin @(negedge clk); c++; end
    apply(3, 0, 0, 0, 0);
    while (!pulse_o) begin @(negedge clk); c++; end
    chk(c == 20, "R9 period kept", c, 20);
    get_period(p);
    chk(p == 6, "R9 new period", p, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule